// File: doc/BRIEF.md
# Decode-Gap SPI Command Master

This block is an SPI master for converter-style peripherals that need a fixed decode time after each received byte. A host hands over one frame per request through a valid/ready handshake. The frame is an opcode, an optional second byte, a number of write bytes and a number of read bytes. The block selects the peripheral, shifts every byte out MSB first and captures the peripheral's reply during the read bytes. It then raises a one-cycle done pulse with the captured data.

Timing that the peripheral sees is derived from two sources. SCLK comes from the system clock through a divider: one SCLK half period lasts `CLK_DIV` system cycles. The decode waits are counted on a separate `mclk_tick` strobe, which fires once per peripheral master-clock period. Between two bytes the block idles for at least `GAP_TICKS` such periods. Before releasing chip select it waits at least `GAP_TICKS` periods as well. When the per-request `req_no_gap` bit is set, bytes follow each other without the inter-byte wait. This is intended for slow SCLK rates where one byte already outlasts the decode time.

Besides raw frames, the block can build the two register-access headers itself from a 5-bit address and a byte count.

Top module: `spi_cmd_master`

## Requirements
- R1: `spi_cs_n` goes low at request acceptance and stays low without interruption until every byte of the frame has been shifted. `spi_sclk` never toggles while `spi_cs_n` is high.
- R2: After the last falling SCLK edge of a frame, `spi_cs_n` stays low for at least `GAP_TICKS` full `mclk_tick` periods before rising. This holds whether or not `req_no_gap` is set.
- R3: With `req_no_gap`=0, the time between the final falling SCLK edge of one byte and the first rising edge of the next covers at least `GAP_TICKS` full `mclk_tick` periods. During that time SCLK is held low.
- R4: SPI mode 1 with MSB first. SCLK idles low. `spi_mosi` changes only on a rising SCLK edge. `spi_miso` is sampled on the falling SCLK edge.
- R5: With `req_no_gap`=1, the next byte's first rising SCLK edge follows the previous byte's last falling edge after exactly one half period (`CLK_DIV` system cycles).
- R6: `req_kind`=1 (register read) with count n sends `{3'b001, req_addr}` and then `{3'b000, n-1}` as a 5-bit field. It then sends n bytes of 0x00 while capturing MISO.
- R7: `req_kind`=2 (register write) with count n sends `{3'b010, req_addr}` and then `{3'b000, n-1}`. It then sends the payload bytes in the order `req_wr_data[7:0]`, `[15:8]`, and so on.
- R8: `req_kind`=0 (raw) sends `req_op`, then `req_arg` if `req_has_arg` is set, then `req_wr_n` payload bytes, then `req_rd_n` bytes of 0x00 whose MISO data is captured.
- R9: `req_ready` is high only while the block is idle. A request presented while a frame is in progress is not accepted and adds no bytes to the frame.
- R10: Between two frames, `spi_cs_n` stays high for at least one SCLK period (2·`CLK_DIV` system cycles).
- R11: `done` is a one-cycle pulse in the cycle `spi_cs_n` rises. At that time `rd_data` holds the read bytes, with the last one received at `[7:0]` and earlier ones above it, and the unused upper bytes at zero.
- R12: After reset, `spi_cs_n`=1, `spi_sclk`=0, `spi_mosi`=0, `req_ready`=1 and `done`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mclk_tick | input | 1 | One-cycle strobe per peripheral master-clock period |
| req_valid | input | 1 | Frame request valid |
| req_ready | output | 1 | Block idle, request will be accepted |
| req_kind | input | 2 | 0 raw, 1 register read, 2 register write |
| req_addr | input | 5 | Register start address for kinds 1 and 2 |
| req_op | input | 8 | Opcode byte for raw frames |
| req_arg | input | 8 | Second byte for raw frames |
| req_has_arg | input | 1 | Raw frame carries `req_arg` |
| req_wr_n | input | CW | Number of payload bytes to write |
| req_wr_data | input | 8·MAXB | Payload bytes, first byte in [7:0] |
| req_rd_n | input | CW | Number of bytes to read |
| req_no_gap | input | 1 | Suppress the inter-byte decode gap |
| done | output | 1 | Frame complete pulse |
| rd_data | output | 8·MAXB | Captured read bytes, last one in [7:0] |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_sclk | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data to peripheral |
| spi_miso | input | 1 | Serial data from peripheral |

## Verification
The hardest situation to reach is the boundary between two bytes. The bench has to tell whether the decode wait actually sits there, or whether SCLK simply keeps running. It also has to confirm that the gap is measured in peripheral clock periods and not in SCLK periods.

To get there, the bench runs `mclk_tick` at a rate unrelated to the SCLK divider. A peripheral model watches the pins and timestamps every byte-ending falling edge and the next rising edge. The same frame shape is then repeated with `req_no_gap` set, so the measured spacing must collapse to one half period while the release wait before chip select stays long.

A request held valid during an active frame covers the ignored-request case.

// File: rtl/spi_cmd_master.sv
module spi_cmd_master #(
  parameter int CLK_DIV   = 2,
  parameter int GAP_TICKS = 4,
  parameter int MAXB      = 4,
  localparam int CW = $clog2(MAXB + 1),
  localparam int IW = $clog2(2 * MAXB + 3),
  localparam int GW = $clog2(GAP_TICKS + 1),
  localparam int HW = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mclk_tick,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [1:0]        req_kind,
  input  logic [4:0]        req_addr,
  input  logic [7:0]        req_op,
  input  logic [7:0]        req_arg,
  input  logic              req_has_arg,
  input  logic [CW-1:0]     req_wr_n,
  input  logic [8*MAXB-1:0] req_wr_data,
  input  logic [CW-1:0]     req_rd_n,
  input  logic              req_no_gap,
  output logic              done,
  output logic [8*MAXB-1:0] rd_data,
  output logic              spi_cs_n,
  output logic              spi_sclk,
  output logic              spi_mosi,
  input  logic              spi_miso
);

  typedef enum logic [2:0] {S_IDLE, S_LO, S_HI, S_GAP, S_TAIL, S_CSH} st_t;

  st_t              st;
  logic [HW-1:0]    hcnt;
  logic [2:0]       bcnt;
  logic [GW-1:0]    gcnt;
  logic [IW-1:0]    idx, last_q, rds_q, nidx, pidx, nbytes;
  logic [7:0]       op_q, arg_q, sh, op_in, arg_in, nbyte;
  logic             has_q, nogap_q, has_in;
  logic [CW-1:0]    wrn_q, wr_in, rd_in;
  logic [8*MAXB-1:0] wr_q;
  logic [6:0]       rx;

  wire htick = (hcnt == '0);
  wire gdone = mclk_tick && (gcnt == GW'(GAP_TICKS));
  assign req_ready = (st == S_IDLE);

  always_comb begin
    op_in  = req_op;
    arg_in = req_arg;
    has_in = req_has_arg;
    wr_in  = req_wr_n;
    rd_in  = req_rd_n;
    case (req_kind)
      2'd1: begin
        op_in  = {3'b001, req_addr};
        arg_in = {3'b000, 5'(req_rd_n - CW'(1))};
        has_in = 1'b1;
        wr_in  = '0;
      end
      2'd2: begin
        op_in  = {3'b010, req_addr};
        arg_in = {3'b000, 5'(req_wr_n - CW'(1))};
        has_in = 1'b1;
        rd_in  = '0;
      end
      default: ;
    endcase
  end

  assign nbytes = IW'(1) + IW'(has_in) + IW'(wr_in) + IW'(rd_in);
  assign nidx   = idx + IW'(1);
  assign pidx   = nidx - IW'(1) - IW'(has_q);

  always_comb begin
    nbyte = 8'h00;
    if (has_q && nidx == IW'(1)) nbyte = arg_q;
    else if (pidx < IW'(wrn_q))  nbyte = wr_q[8*pidx +: 8];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; hcnt <= '0; bcnt <= '0; gcnt <= '0;
      idx <= '0; last_q <= '0; rds_q <= '0;
      op_q <= '0; arg_q <= '0; has_q <= 1'b0; nogap_q <= 1'b0;
      wrn_q <= '0; wr_q <= '0; sh <= '0; rx <= '0;
      rd_data <= '0; done <= 1'b0;
      spi_cs_n <= 1'b1; spi_sclk <= 1'b0; spi_mosi <= 1'b0;
    end else begin
      done <= 1'b0;
      hcnt <= (htick || st == S_IDLE || st == S_GAP || st == S_TAIL)
              ? HW'(CLK_DIV - 1) : hcnt - HW'(1);
      case (st)
        S_IDLE: if (req_valid) begin
          op_q <= op_in; arg_q <= arg_in; has_q <= has_in;
          wrn_q <= wr_in; wr_q <= req_wr_data; nogap_q <= req_no_gap;
          last_q <= nbytes - IW'(1);
          rds_q  <= nbytes - IW'(rd_in);
          idx <= '0; bcnt <= 3'd7; sh <= op_in;
          rd_data <= '0; spi_cs_n <= 1'b0; st <= S_LO;
        end
        S_LO: if (htick) begin
          spi_sclk <= 1'b1;
          spi_mosi <= sh[7];
          sh <= {sh[6:0], 1'b0};
          st <= S_HI;
        end
        S_HI: if (htick) begin
          spi_sclk <= 1'b0;
          rx <= {rx[5:0], spi_miso};
          if (bcnt == 3'd0) begin
            if (idx >= rds_q) rd_data <= {rd_data[8*MAXB-9:0], rx, spi_miso};
            gcnt <= '0;
            if (idx == last_q) st <= S_TAIL;
            else begin
              idx <= nidx; sh <= nbyte; bcnt <= 3'd7;
              st <= nogap_q ? S_LO : S_GAP;
            end
          end else begin
            bcnt <= bcnt - 3'd1;
            st <= S_LO;
          end
        end
        S_GAP: if (mclk_tick) begin
          if (gdone) st <= S_LO;
          else gcnt <= gcnt + GW'(1);
        end
        S_TAIL: if (mclk_tick) begin
          if (gdone) begin
            spi_cs_n <= 1'b1; done <= 1'b1; bcnt <= 3'd1; st <= S_CSH;
          end else gcnt <= gcnt + GW'(1);
        end
        S_CSH: if (htick) begin
          if (bcnt == 3'd0) st <= S_IDLE;
          else bcnt <= bcnt - 3'd1;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  a_r1_sclk_needs_cs: assert property (@(posedge clk) disable iff (!rst_n)
    spi_sclk |-> !spi_cs_n);
  a_r4_mosi_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(spi_mosi) |-> $rose(spi_sclk));
  a_r3_gap_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_GAP) |-> (!spi_sclk && !spi_cs_n));
  a_r2_release_after_tail: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(spi_cs_n) |-> ($past(st) == S_TAIL && $past(gdone)));
  a_r11_done_at_release: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $rose(spi_cs_n));
  a_r9_ready_only_idle: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (spi_cs_n && !spi_sclk));
  a_r10_cs_high_hold: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(spi_cs_n) |=> spi_cs_n);

endmodule

// File: tb/sim_spi_cmd_master.sv
`timescale 1ns/100ps
module sim_spi_cmd_master;
  localparam int DIV = 2, GAP = 4, MAXB = 4, MT = 5;
  localparam int CW = $clog2(MAXB + 1);

  logic clk = 0, rst_n = 0, mclk_tick = 0;
  logic req_valid = 0, req_has_arg = 0, req_no_gap = 0, spi_miso = 0;
  logic [1:0] req_kind = 0;
  logic [4:0] req_addr = 0;
  logic [7:0] req_op = 0, req_arg = 0;
  logic [CW-1:0] req_wr_n = 0, req_rd_n = 0;
  logic [8*MAXB-1:0] req_wr_data = 0;
  logic req_ready, done, spi_cs_n, spi_sclk, spi_mosi;
  logic [8*MAXB-1:0] rd_data;

  always #2 clk = ~clk;

  spi_cmd_master #(.CLK_DIV(DIV), .GAP_TICKS(GAP), .MAXB(MAXB)) u0 (
    .clk, .rst_n, .mclk_tick, .req_valid, .req_ready, .req_kind, .req_addr,
    .req_op, .req_arg, .req_has_arg, .req_wr_n, .req_wr_data, .req_rd_n,
    .req_no_gap, .done, .rd_data, .spi_cs_n, .spi_sclk, .spi_mosi, .spi_miso);

  int checks = 0, fails = 0, cyc = 0, mt_cnt = 0;
  logic [7:0] seen [0:15];
  int nseen, bitc, last_fall, min_gap, tail, rise_cyc, cs_hi_len, hi_edges, done_cnt, falls;
  bit seen_rise = 0, done_flag = 0;
  logic [7:0] osh, ish;
  logic [8*MAXB-1:0] rd_cap;
  logic pcs = 1, psclk = 0;

  function automatic logic [7:0] resp(int b);
    return 8'h5A ^ 8'(b * 8'h13);
  endfunction

  task automatic chk(bit ok, string req, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      fails++;
      $display("FAIL watchdog: actual %0d expected below %0d", cyc, 150000);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  always @(negedge clk) begin
    mt_cnt = (mt_cnt == MT - 1) ? 0 : mt_cnt + 1;
    mclk_tick = (mt_cnt == 0);
    if (pcs && !spi_cs_n) begin
      if (seen_rise) cs_hi_len = cyc - rise_cyc;
      falls++; nseen = 0; bitc = 0; osh = resp(0);
      min_gap = 1 << 30; last_fall = -1;
    end
    if (!pcs && spi_cs_n) begin
      tail = cyc - last_fall; rise_cyc = cyc; seen_rise = 1;
    end
    if (spi_cs_n && spi_sclk != psclk) hi_edges++;
    if (!spi_cs_n && !psclk && spi_sclk) begin
      if (bitc == 0 && nseen > 0 && cyc - last_fall < min_gap) min_gap = cyc - last_fall;
      spi_miso = osh[7]; osh = {osh[6:0], 1'b0}; bitc++;
    end
    if (!spi_cs_n && psclk && !spi_sclk) begin
      ish = {ish[6:0], spi_mosi};
      if (bitc == 8) begin
        if (nseen < 16) seen[nseen] = ish;
        nseen++; bitc = 0; osh = resp(nseen); last_fall = cyc;
      end
    end
    if (done) begin done_flag = 1; done_cnt++; rd_cap = rd_data; end
    pcs = spi_cs_n; psclk = spi_sclk;
  end

  task automatic issue(logic [1:0] k, logic [4:0] a, logic [7:0] op, logic [7:0] arg,
                       logic has, int wn, logic [8*MAXB-1:0] wd, int rn, logic ng);
    @(negedge clk);
    req_kind = k; req_addr = a; req_op = op; req_arg = arg; req_has_arg = has;
    req_wr_n = CW'(wn); req_wr_data = wd; req_rd_n = CW'(rn); req_no_gap = ng;
    done_flag = 0; done_cnt = 0; req_valid = 1;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic wait_done();
    for (int i = 0; i < 5000 && !done_flag; i++) @(posedge clk);
    repeat (4 * DIV) @(posedge clk);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(spi_cs_n == 1, "R12 cs_n", spi_cs_n, 1);
    chk(spi_sclk == 0, "R12 sclk", spi_sclk, 0);
    chk(spi_mosi == 0, "R12 mosi", spi_mosi, 0);
    chk(req_ready == 1, "R12 ready", req_ready, 1);
    chk(done == 0, "R12 done", done, 0);
  endtask

  task automatic t_raw_single();
    issue(2'd0, 5'd0, 8'h0A, 8'h00, 0, 0, '0, 0, 0);
    wait_done();
    chk(nseen == 1, "R8 raw byte count", nseen, 1);
    chk(seen[0] == 8'h0A, "R4 R8 raw opcode", seen[0], 8'h0A);
    chk(tail >= GAP * MT, "R2 tail", tail, GAP * MT);
    chk(done_cnt == 1, "R11 done width", done_cnt, 1);
  endtask

  task automatic t_rreg();
    issue(2'd1, 5'd5, 8'h00, 8'h00, 0, 0, '0, 2, 0);
    wait_done();
    chk(nseen == 4, "R1 R6 rreg count", nseen, 4);
    chk(seen[0] == 8'h25, "R6 rreg header", seen[0], 8'h25);
    chk(seen[1] == 8'h01, "R6 rreg count field", seen[1], 8'h01);
    chk(seen[2] == 8'h00 && seen[3] == 8'h00, "R6 rreg dummy", {seen[2], seen[3]}, 0);
    chk(min_gap >= GAP * MT, "R3 gap", min_gap, GAP * MT);
    chk(rd_cap == {16'h0, resp(2), resp(3)}, "R11 R4 rreg data", rd_cap, {16'h0, resp(2), resp(3)});
  endtask

  task automatic t_wreg();
    issue(2'd2, 5'd3, 8'h00, 8'h00, 0, 3, 32'h00C3C2C1, 0, 0);
    wait_done();
    chk(nseen == 5, "R7 wreg count", nseen, 5);
    chk(seen[0] == 8'h43 && seen[1] == 8'h02, "R7 wreg header", {seen[0], seen[1]}, 16'h4302);
    chk(seen[2] == 8'hC1 && seen[3] == 8'hC2 && seen[4] == 8'hC3, "R7 wreg payload order",
        {seen[2], seen[3], seen[4]}, 24'hC1C2C3);
    chk(min_gap >= GAP * MT, "R3 wreg gap", min_gap, GAP * MT);
    chk(rd_cap == '0, "R11 no read bytes", rd_cap, 0);
  endtask

  task automatic t_nogap();
    issue(2'd0, 5'd0, 8'h12, 8'h34, 1, 1, 32'h77, 2, 1);
    wait_done();
    chk(nseen == 5, "R8 nogap count", nseen, 5);
    chk(seen[0] == 8'h12 && seen[1] == 8'h34 && seen[2] == 8'h77 && seen[3] == 8'h00,
        "R8 raw order", {seen[0], seen[1], seen[2], seen[3]}, 32'h12347700);
    chk(min_gap == DIV, "R5 nogap spacing", min_gap, DIV);
    chk(tail >= GAP * MT, "R2 tail with nogap", tail, GAP * MT);
    chk(rd_cap == {16'h0, resp(3), resp(4)}, "R11 nogap data", rd_cap, {16'h0, resp(3), resp(4)});
  endtask

  task automatic t_busy();
    int f0;
    bit rdy_seen = 0;
    issue(2'd1, 5'd1, 8'h00, 8'h00, 0, 0, '0, 3, 0);
    @(negedge clk);
    req_kind = 0; req_op = 8'h99; req_has_arg = 0; req_wr_n = 0; req_rd_n = 0; req_valid = 1;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (req_ready) rdy_seen = 1;
    end
    req_valid = 0;
    chk(!rdy_seen, "R9 ready low while busy", rdy_seen, 0);
    wait_done();
    f0 = falls;
    chk(nseen == 5 && seen[0] == 8'h21 && seen[1] == 8'h02, "R9 frame unaffected",
        {seen[0], seen[1]}, 16'h2102);
    repeat (60) @(negedge clk);
    chk(falls == f0 && spi_cs_n == 1, "R9 busy request dropped", falls, f0);
  endtask

  task automatic t_b2b();
    issue(2'd0, 5'd0, 8'h08, 8'h00, 0, 0, '0, 0, 1);
    for (int i = 0; i < 5000 && !done_flag; i++) @(posedge clk);
    issue(2'd0, 5'd0, 8'h0A, 8'h00, 0, 0, '0, 0, 1);
    wait_done();
    chk(cs_hi_len >= 2 * DIV, "R10 cs high between frames", cs_hi_len, 2 * DIV);
    chk(seen[0] == 8'h0A, "R8 second frame", seen[0], 8'h0A);
    chk(hi_edges == 0, "R1 no sclk with cs high", hi_edges, 0);
  endtask

  initial begin
    hi_edges = 0; falls = 0; nseen = 0; bitc = 0; done_cnt = 0;
    tail = 0; min_gap = 0; last_fall = -1; cs_hi_len = 0; rise_cyc = 0;
    osh = 0; ish = 0; rd_cap = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_raw_single();
    t_rreg();
    t_wreg();
    t_nogap();
    t_busy();
    t_b2b();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule